// File: doc/BRIEF.md
# Coprocessor Result Scoreboard

This block tracks which entries of a 256-entry register file are still waiting on a result from a long-running library function. A library function runs on a coprocessor alongside ordinary instructions. When decode issues such a function, the destination entry becomes pending. When the coprocessor reports completion, it writes the result into the entry and the entry becomes ready again. On every instruction presented to decode, the block looks up the entries that instruction needs. If any of them is pending, it raises a stall and decode holds the instruction.

Three source slots, each with its own use bit, can be checked per instruction. There is also an explicit wait request naming one entry, and the destination of a new function issue is checked too. A completion in the same cycle counts as ready at once, and its data is forwarded to the source read ports. A global clear from the execution time guard wipes the whole scoreboard and zeroes the stored data.

Top module: `cop_scoreboard`

## Requirements
- R1: After reset every entry is ready and reads as zero, and `dec_stall` is low.
- R2: An accepted function issue (`dec_valid` and `dec_is_func` high, `dec_stall` low) marks entry `dec_dst` pending from the next cycle on. A later instruction that uses that entry as a source then stalls.
- R3: A completion (`cop_done`, `cop_idx`, `cop_data`) writes `cop_data` into entry `cop_idx` and makes it ready. Later reads of that entry return the data with no stall.
- R4: `dec_stall` is high when any source slot whose `dec_src_use` bit is set (bit 0 for `dec_src0`, bit 1 for `dec_src1`, bit 2 for `dec_src2`) names a pending entry. A slot whose use bit is clear is ignored.
- R5: An instruction whose used entries are all ready proceeds without stall while other entries are pending.
- R6: A wait request (`dec_wait`) stalls while entry `dec_wait_idx` is pending and does not stall once it is ready.
- R7: A function issue whose destination is already pending stalls until that entry is ready.
- R8: A completion in the same cycle as a lookup counts as ready for that lookup. The matching source data port then shows `cop_data` in that cycle.
- R9: A completion and an accepted issue that name the same entry in the same cycle leave that entry pending.
- R10: `guard_clear` holds `dec_stall` high in its cycle and drops any issue in that cycle. From the next cycle every entry is ready and reads as zero.
- R11: A function issue that stalls on a source does not mark its destination pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_valid | input | 1 | Decode presents an instruction |
| dec_src_use | input | 3 | Use bits for the three source slots |
| dec_src0 | input | 8 | Source slot 0 entry index |
| dec_src1 | input | 8 | Source slot 1 entry index |
| dec_src2 | input | 8 | Source slot 2 entry index |
| dec_is_func | input | 1 | Instruction issues a library function |
| dec_dst | input | 8 | Destination entry of the function |
| dec_wait | input | 1 | Instruction is an explicit wait |
| dec_wait_idx | input | 8 | Entry named by the wait |
| cop_done | input | 1 | Coprocessor completion strobe |
| cop_idx | input | 8 | Entry the completion writes |
| cop_data | input | 32 | Result data |
| guard_clear | input | 1 | Global clear from the time guard |
| dec_stall | output | 1 | Decode must hold the instruction |
| func_issue | output | 1 | Function issue accepted this cycle |
| src_data0 | output | 32 | Data of source slot 0 |
| src_data1 | output | 32 | Data of source slot 1 |
| src_data2 | output | 32 | Data of source slot 2 |

## Verification
The hardest case to reach from the ports is a completion and an issue landing on the same entry in one cycle. The issue is only accepted because the same-cycle completion makes the pending destination look ready, so the stimulus first makes the entry pending and then drives both strobes in the next cycle. A read one cycle later must then stall. A similar case is a clear that arrives together with an issue. Here the stimulus first leaves one entry pending and writes data to a second one, then raises the clear alongside a new issue, and reads all three entries afterwards.

// File: rtl/sb_pkg.sv
// Package: shared constants and lookup slot numbering for the scoreboard.
// Assumes five readiness lookups per decoded instruction.
package sb_pkg;
    localparam int NUM_SRC = 3;
    localparam int NUM_LK  = NUM_SRC + 2;

    // Lookup slot order inside the hazard checker
    typedef enum int {
        LK_SRC0 = 0,
        LK_SRC1 = 1,
        LK_SRC2 = 2,
        LK_WAIT = 3,
        LK_DST  = 4
    } lookup_e;
endpackage

// File: rtl/sb_pending.sv
// Module: pending-bit vector, one bit per register entry.
// A set and a clear to the same entry leave it set; a global clear wins over both.
// Assumes set_en is only raised for accepted issues.
module sb_pending #(
    parameter int NUM_REGS = 256,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wipe,
    input  logic                set_en,
    input  logic [IDX_W-1:0]    set_idx,
    input  logic                clr_en,
    input  logic [IDX_W-1:0]    clr_idx,
    output logic [NUM_REGS-1:0] pend_q
);
    // Update the pending bits: wipe, then set, then completion clear
    always_ff @(posedge clk) begin
        if (!rst_n || wipe) begin
            pend_q <= '0;
        end else begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (set_en && set_idx == IDX_W'(i))
                    pend_q[i] <= 1'b1;
                else if (clr_en && clr_idx == IDX_W'(i))
                    pend_q[i] <= 1'b0;
            end
        end
    end

    a_r2_issue_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && !wipe) |=> pend_q[$past(set_idx)]);
    a_r3_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !wipe && !(set_en && set_idx == clr_idx)) |=> !pend_q[$past(clr_idx)]);
    a_r9_same_entry_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && set_en && set_idx == clr_idx && !wipe) |=> pend_q[$past(clr_idx)]);
    a_r10_wipe_all: assert property (@(posedge clk) disable iff (!rst_n)
        wipe |=> (pend_q == '0));
endmodule

// File: rtl/sb_regfile.sv
// Module: result storage with three read ports and completion forwarding.
// A completion writes its data; a read of the entry being written in the same
// cycle returns the incoming data. The global clear zeroes every entry.
module sb_regfile #(
    parameter int NUM_REGS = 256,
    parameter int DATA_W   = 32,
    parameter int NUM_RD   = 3,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wipe,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic [NUM_RD-1:0][IDX_W-1:0]  rd_idx,
    output logic [NUM_RD-1:0][DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [NUM_REGS];

    // Store completion results, zero on reset or wipe
    always_ff @(posedge clk) begin
        if (!rst_n || wipe) begin
            for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        // Read one port, forwarding a same-cycle completion
        always_comb begin
            if (wr_en && !wipe && wr_idx == rd_idx[p])
                rd_data[p] = wr_data;
            else
                rd_data[p] = mem[rd_idx[p]];
        end
    end

    a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wipe) |=> (mem[$past(wr_idx)] == $past(wr_data)));
    a_r10_wipe_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wipe |=> (mem[$past(rd_idx[0])] == '0));
endmodule

// File: rtl/sb_hazard.sv
// Module: readiness lookups for one decoded instruction.
// Each enabled lookup is blocked when its entry is pending and no completion
// for that entry arrives in the same cycle.
module sb_hazard #(
    parameter int NUM_REGS = 256,
    parameter int NUM_LK   = 5,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic [NUM_REGS-1:0]          pend_q,
    input  logic [NUM_LK-1:0]            lk_en,
    input  logic [NUM_LK-1:0][IDX_W-1:0] lk_idx,
    input  logic                         byp_en,
    input  logic [IDX_W-1:0]             byp_idx,
    output logic [NUM_LK-1:0]            blocked,
    output logic                         any_blocked
);
    for (genvar k = 0; k < NUM_LK; k++) begin : g_lk
        logic hit_byp;
        // Decide whether lookup k sees a pending entry
        always_comb begin
            hit_byp    = byp_en && (byp_idx == lk_idx[k]);
            blocked[k] = lk_en[k] && pend_q[lk_idx[k]] && !hit_byp;
        end
    end

    // Combine the lookups into one stall request
    always_comb any_blocked = |blocked;
endmodule

// File: rtl/cop_scoreboard.sv
// Module: top of the coprocessor result scoreboard.
// Builds the lookup list from the decode inputs and drives the stall. It
// accepts function issues and routes completions into the pending vector and
// the result storage. Assumes decode holds its inputs while dec_stall is high.
module cop_scoreboard #(
    parameter int NUM_REGS = 256,
    parameter int DATA_W   = 32,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec_valid,
    input  logic [2:0]        dec_src_use,
    input  logic [IDX_W-1:0]  dec_src0,
    input  logic [IDX_W-1:0]  dec_src1,
    input  logic [IDX_W-1:0]  dec_src2,
    input  logic              dec_is_func,
    input  logic [IDX_W-1:0]  dec_dst,
    input  logic              dec_wait,
    input  logic [IDX_W-1:0]  dec_wait_idx,
    input  logic              cop_done,
    input  logic [IDX_W-1:0]  cop_idx,
    input  logic [DATA_W-1:0] cop_data,
    input  logic              guard_clear,
    output logic              dec_stall,
    output logic              func_issue,
    output logic [DATA_W-1:0] src_data0,
    output logic [DATA_W-1:0] src_data1,
    output logic [DATA_W-1:0] src_data2
);
    import sb_pkg::*;

    logic [NUM_REGS-1:0]                  pend_q;
    logic [NUM_LK-1:0]                    lk_en;
    logic [NUM_LK-1:0][IDX_W-1:0]         lk_idx;
    logic [NUM_LK-1:0]                    blocked;
    logic                                 any_blocked;
    logic [NUM_SRC-1:0][IDX_W-1:0]        rd_idx;
    logic [NUM_SRC-1:0][DATA_W-1:0]       rd_data;

    // Assemble the lookup list for the current instruction
    always_comb begin
        rd_idx[0] = dec_src0;
        rd_idx[1] = dec_src1;
        rd_idx[2] = dec_src2;
        for (int s = 0; s < NUM_SRC; s++) begin
            lk_en[s]  = dec_valid && dec_src_use[s];
            lk_idx[s] = rd_idx[s];
        end
        lk_en[LK_WAIT]  = dec_valid && dec_wait;
        lk_idx[LK_WAIT] = dec_wait_idx;
        lk_en[LK_DST]   = dec_valid && dec_is_func;
        lk_idx[LK_DST]  = dec_dst;
    end

    // Stall on a blocked lookup or during a clear; accept unstalled issues
    always_comb begin
        dec_stall  = guard_clear || any_blocked;
        func_issue = dec_valid && dec_is_func && !dec_stall;
    end

    sb_hazard #(.NUM_REGS(NUM_REGS), .NUM_LK(NUM_LK)) i_hazard (
        .pend_q      (pend_q),
        .lk_en       (lk_en),
        .lk_idx      (lk_idx),
        .byp_en      (cop_done),
        .byp_idx     (cop_idx),
        .blocked     (blocked),
        .any_blocked (any_blocked)
    );

    sb_pending #(.NUM_REGS(NUM_REGS)) i_pending (
        .clk     (clk),
        .rst_n   (rst_n),
        .wipe    (guard_clear),
        .set_en  (func_issue),
        .set_idx (dec_dst),
        .clr_en  (cop_done),
        .clr_idx (cop_idx),
        .pend_q  (pend_q)
    );

    sb_regfile #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .NUM_RD(NUM_SRC)) i_regfile (
        .clk     (clk),
        .rst_n   (rst_n),
        .wipe    (guard_clear),
        .wr_en   (cop_done),
        .wr_idx  (cop_idx),
        .wr_data (cop_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    // Drive the source data ports
    always_comb begin
        src_data0 = rd_data[0];
        src_data1 = rd_data[1];
        src_data2 = rd_data[2];
    end

    a_r4_src_pending_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_src_use[0] && pend_q[dec_src0] && !(cop_done && cop_idx == dec_src0))
        |-> dec_stall);
    a_r6_wait_pending_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_wait && pend_q[dec_wait_idx] && !(cop_done && cop_idx == dec_wait_idx))
        |-> dec_stall);
    a_r5_free_instr_runs: assert property (@(posedge clk) disable iff (!rst_n)
        (!guard_clear && dec_src_use == 3'b000 && !dec_wait && !dec_is_func) |-> !dec_stall);
    a_r11_stalled_no_mark: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_is_func && dec_stall && !pend_q[dec_dst] && !guard_clear) |=> !pend_q[$past(dec_dst)]);
    a_r10_clear_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        guard_clear |-> (dec_stall && !func_issue));
endmodule

// File: tb/test_cop_scoreboard.sv
// Bench: directed scenarios, one task each. Inputs change after the falling
// edge; combinational outputs are sampled 1 ns later, before the rising edge.
module test_cop_scoreboard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dec_valid = 1'b0;
    logic [2:0]  dec_src_use = '0;
    logic [7:0]  dec_src0 = '0, dec_src1 = '0, dec_src2 = '0;
    logic        dec_is_func = 1'b0;
    logic [7:0]  dec_dst = '0;
    logic        dec_wait = 1'b0;
    logic [7:0]  dec_wait_idx = '0;
    logic        cop_done = 1'b0;
    logic [7:0]  cop_idx = '0;
    logic [31:0] cop_data = '0;
    logic        guard_clear = 1'b0;
    logic        dec_stall, func_issue;
    logic [31:0] src_data0, src_data1, src_data2;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    cop_scoreboard i_cop_scoreboard (
        .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_src_use(dec_src_use),
        .dec_src0(dec_src0), .dec_src1(dec_src1), .dec_src2(dec_src2),
        .dec_is_func(dec_is_func), .dec_dst(dec_dst), .dec_wait(dec_wait),
        .dec_wait_idx(dec_wait_idx), .cop_done(cop_done), .cop_idx(cop_idx),
        .cop_data(cop_data), .guard_clear(guard_clear), .dec_stall(dec_stall),
        .func_issue(func_issue), .src_data0(src_data0), .src_data1(src_data1),
        .src_data2(src_data2)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Return all inputs to idle
    task automatic idle();
        dec_valid = 0; dec_src_use = 0; dec_src0 = 0; dec_src1 = 0; dec_src2 = 0;
        dec_is_func = 0; dec_dst = 0; dec_wait = 0; dec_wait_idx = 0;
        cop_done = 0; cop_idx = 0; cop_data = 0; guard_clear = 0;
    endtask

    // Finish the current cycle: let the rising edge pass, stop at the falling edge
    task automatic next();
        @(negedge clk);
        idle();
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic issue(input logic [7:0] dst);
        dec_valid = 1; dec_is_func = 1; dec_dst = dst; settle();
        next();
    endtask

    task automatic complete(input logic [7:0] idx, input logic [31:0] d);
        cop_done = 1; cop_idx = idx; cop_data = d; settle();
        next();
    endtask

    // Read one entry through slot 0 and check stall and data
    task automatic read0(input string req, input logic [7:0] idx, input logic st, input logic [31:0] d);
        dec_valid = 1; dec_src_use = 3'b001; dec_src0 = idx; settle();
        chk(req, "stall", dec_stall, st);
        chk(req, "data", src_data0, d);
        next();
    endtask

    task automatic t_reset();
        read0("R1", 8'd5, 0, 0);
        read0("R1", 8'd255, 0, 0);
    endtask

    task automatic t_issue_and_lookups();
        dec_valid = 1; dec_is_func = 1; dec_dst = 10; settle();
        chk("R2", "issue accepted", func_issue, 1);
        chk("R2", "no stall at issue", dec_stall, 0);
        next();
        read0("R2", 8'd10, 1, 0);
        // R4: slot 1 names the pending entry but its use bit is clear
        dec_valid = 1; dec_src_use = 3'b001; dec_src0 = 3; dec_src1 = 10; settle();
        chk("R4", "unused slot ignored", dec_stall, 0);
        next();
        // R5: all used entries ready
        dec_valid = 1; dec_src_use = 3'b111; dec_src0 = 3; dec_src1 = 4; dec_src2 = 5; settle();
        chk("R5", "independent proceeds", dec_stall, 0);
        next();
        dec_valid = 1; dec_wait = 1; dec_wait_idx = 10; settle();
        chk("R6", "wait on pending", dec_stall, 1);
        next();
        dec_valid = 1; dec_wait = 1; dec_wait_idx = 11; settle();
        chk("R6", "wait on ready", dec_stall, 0);
        next();
        dec_valid = 1; dec_is_func = 1; dec_dst = 10; settle();
        chk("R7", "issue on pending dst stalls", dec_stall, 1);
        chk("R7", "issue not accepted", func_issue, 0);
        next();
        // R11: function stalled on its source must not mark its destination
        dec_valid = 1; dec_is_func = 1; dec_dst = 20; dec_src_use = 3'b001; dec_src0 = 10; settle();
        chk("R11", "stalled on source", dec_stall, 1);
        next();
        read0("R11", 8'd20, 0, 0);
        complete(8'd10, 32'h0000A5A5);
        read0("R3", 8'd10, 0, 32'h0000A5A5);
        dec_valid = 1; dec_wait = 1; dec_wait_idx = 10; settle();
        chk("R6", "wait after completion", dec_stall, 0);
        next();
    endtask

    task automatic t_top_slot();
        issue(8'd255);
        dec_valid = 1; dec_src_use = 3'b100; dec_src2 = 255; settle();
        chk("R4", "slot 2 pending", dec_stall, 1);
        next();
        complete(8'd255, 32'hDEADBEEF);
        dec_valid = 1; dec_src_use = 3'b100; dec_src2 = 255; settle();
        chk("R4", "slot 2 ready", dec_stall, 0);
        chk("R3", "slot 2 data", src_data2, 32'hDEADBEEF);
        next();
    endtask

    task automatic t_bypass();
        issue(8'd30);
        dec_valid = 1; dec_src_use = 3'b010; dec_src1 = 30;
        cop_done = 1; cop_idx = 30; cop_data = 32'h1234; settle();
        chk("R8", "same-cycle completion no stall", dec_stall, 0);
        chk("R8", "forwarded data", src_data1, 32'h1234);
        next();
        read0("R8", 8'd30, 0, 32'h1234);
    endtask

    task automatic t_same_entry();
        issue(8'd40);
        dec_valid = 1; dec_is_func = 1; dec_dst = 40;
        cop_done = 1; cop_idx = 40; cop_data = 32'h7; settle();
        chk("R9", "reissue accepted with completion", func_issue, 1);
        next();
        read0("R9", 8'd40, 1, 32'h7);
        complete(8'd40, 32'h8);
        read0("R9", 8'd40, 0, 32'h8);
    endtask

    task automatic t_clear();
        issue(8'd50);
        complete(8'd60, 32'h55);
        read0("R3", 8'd60, 0, 32'h55);
        dec_valid = 1; dec_is_func = 1; dec_dst = 70; guard_clear = 1; settle();
        chk("R10", "stall during clear", dec_stall, 1);
        chk("R10", "issue dropped", func_issue, 0);
        next();
        read0("R10", 8'd50, 0, 0);
        read0("R10", 8'd60, 0, 0);
        read0("R10", 8'd70, 0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_issue_and_lookups();
        t_top_slot();
        t_bypass();
        t_same_entry();
        t_clear();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule